// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This unit sits between the memory stage of a processor pipeline and a 32-bit, word-wide data memory. Each cycle it can accept one access. An access is an opcode, a base register value, a signed 16-bit displacement and, for stores, the source register value. The unit adds the sign-extended displacement to the base to form the byte address. It decodes the access size and direction from the opcode. For stores it drives a per-lane write mask together with write data copied into every lane. The memory is byte addressed and big-endian: within a word, the byte at the lowest address is the most significant one.

The request side has one register stage. Memory is assumed to return the addressed word on the cycle after the request appears. The unit remembers what each read asked for. One cycle after the word arrives, it presents the selected byte, halfword or word, sign- or zero-extended to 32 bits. An access whose address is not a multiple of its size raises a misalignment flag and never reaches memory.

Top module: `be_lane_lsu`

## Requirements
- R1: The address on `mem_addr_o` equals `base_i` plus `offset_i` sign-extended to 32 bits, presented one cycle after the access is offered.
- R2: Opcodes are decoded as 32 signed byte load, 33 signed halfword load, 35 word load, 36 unsigned byte load, 37 unsigned halfword load, 40 byte store, 41 halfword store, 43 word store. Any other opcode, or `acc_valid_i` low, produces no request and no misalignment flag.
- R3: The lane mask `mem_be_o` is big-endian. A byte at address offset k (0..3) within the word enables mask bit 3-k. A halfword at offset 0 gives 1100 and at offset 2 gives 0011. A word gives 1111.
- R4: Store data is copied across the lanes. A byte store drives four copies of source bits 7:0, a halfword store drives two copies of source bits 15:0, and a word store drives the source unchanged.
- R5: A store raises `mem_we_o` together with `mem_req_o`. A load raises `mem_req_o` with `mem_we_o` low and the same lane mask a store of that size would use.
- R6: The memory word is taken from `mem_rdata_i` in the cycle after a load request. `ld_valid_o` and `ld_data_o` follow one cycle later. A byte at offset k is taken from word bits 31-8k down to 24-8k, a halfword at offset 0 from bits 31:16 and at offset 2 from bits 15:0.
- R7: Signed byte and halfword loads copy the top bit of the loaded unit into all higher result bits. Unsigned ones fill those bits with zero.
- R8: A halfword access with address bit 0 set, or a word access with address bits 1:0 not zero, raises `misalign_o` in the cycle its request would have appeared. In that cycle `mem_req_o`, `mem_we_o` and `mem_be_o` stay zero, and no load result follows.
- R9: While `rst_n` is low, every output is zero.
- R10: Accesses may be offered on every cycle. Each one is handled on its own, with no stall and no interference between neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | An access is offered this cycle |
| acc_op_i | input | 6 | Access opcode |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| st_src_i | input | 32 | Store source register value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_be_o | output | 4 | Lane mask, bit 3 is the lowest-addressed byte |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| mem_rdata_i | input | 32 | Word returned by memory the cycle after a read |
| misalign_o | output | 1 | Access dropped because it is misaligned |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Extended load result |

## Verification
The hardest case to reach from the ports is a load that reads a word which a store changed one or two cycles earlier, while other accesses are still in flight. In that case a wrong lane mask and a wrong extraction can cover for each other. The stimulus drives a small word-addressed memory model in the bench, and random base and displacement values fold into only sixteen words. Stores and sub-word loads of every size and offset therefore land back to back on the same words. The expected values come from memory contents chosen so that bit 7 and bit 15 of the loaded units take both values.

// File: rtl/lsu_be_pkg.sv
package lsu_be_pkg;

  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int LANE_N = WORD_W / LANE_W;
  localparam int LOFF_W = $clog2(LANE_N);
  localparam int OP_W   = 6;

  localparam logic [OP_W-1:0] OPC_LDB  = 6'd32;
  localparam logic [OP_W-1:0] OPC_LDH  = 6'd33;
  localparam logic [OP_W-1:0] OPC_LDW  = 6'd35;
  localparam logic [OP_W-1:0] OPC_LDBU = 6'd36;
  localparam logic [OP_W-1:0] OPC_LDHU = 6'd37;
  localparam logic [OP_W-1:0] OPC_STB  = 6'd40;
  localparam logic [OP_W-1:0] OPC_STH  = 6'd41;
  localparam logic [OP_W-1:0] OPC_STW  = 6'd43;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_HALF = 2'd2,
    SZ_WORD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic      load;
    logic      store;
    logic      sext;
    acc_size_e size;
  } acc_desc_t;

  // number of bytes covered by an access of the given size
  function automatic int size_bytes(input acc_size_e sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return LANE_N;
      default: return 0;
    endcase
  endfunction

  function automatic acc_desc_t op_decode(input logic [OP_W-1:0] op);
    acc_desc_t d;
    d = '0;
    case (op)
      OPC_LDB:  begin d.load  = 1'b1; d.sext = 1'b1; d.size = SZ_BYTE; end
      OPC_LDH:  begin d.load  = 1'b1; d.sext = 1'b1; d.size = SZ_HALF; end
      OPC_LDW:  begin d.load  = 1'b1;                d.size = SZ_WORD; end
      OPC_LDBU: begin d.load  = 1'b1;                d.size = SZ_BYTE; end
      OPC_LDHU: begin d.load  = 1'b1;                d.size = SZ_HALF; end
      OPC_STB:  begin d.store = 1'b1;                d.size = SZ_BYTE; end
      OPC_STH:  begin d.store = 1'b1;                d.size = SZ_HALF; end
      OPC_STW:  begin d.store = 1'b1;                d.size = SZ_WORD; end
      default:  d = '0;
    endcase
    return d;
  endfunction

  // sizes are powers of two, so alignment is a mask test on the low bits
  function automatic logic is_misaligned(input acc_size_e sz, input logic [LOFF_W-1:0] off);
    int nb;
    nb = size_bytes(sz);
    if (nb == 0) return 1'b0;
    return (off & LOFF_W'(nb - 1)) != '0;
  endfunction

  // bring the addressed unit down to bit 0 and extend it
  function automatic logic [WORD_W-1:0] load_align(input acc_size_e sz, input logic sext,
                                                   input logic [LOFF_W-1:0] off,
                                                   input logic [WORD_W-1:0] word);
    int nb;
    int sh;
    int top;
    logic fill;
    logic [WORD_W-1:0] v;
    logic [WORD_W-1:0] res;
    nb = size_bytes(sz);
    sh = LANE_W * (LANE_N - int'(off) - nb);
    if (nb == 0 || sh < 0) return '0;
    v    = word >> sh;
    top  = LANE_W * nb - 1;
    fill = sext & v[top];
    for (int b = 0; b < WORD_W; b++) res[b] = (b <= top) ? v[b] : fill;
    return res;
  endfunction

endpackage

// File: rtl/lsu_be_agen.sv
module lsu_be_agen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  disp,
  output logic [ADDR_W-1:0] ea
);
  generate
    if (ADDR_W > OFF_W) begin : g_ext
      assign ea = base + {{(ADDR_W-OFF_W){disp[OFF_W-1]}}, disp};
    end else begin : g_trunc
      assign ea = base + disp[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/lsu_be_decode.sv
module lsu_be_decode
  import lsu_be_pkg::*;
(
  input  logic                valid,
  input  logic [OP_W-1:0]     op,
  input  logic [LOFF_W-1:0]   ea_lo,
  output acc_desc_t           desc,
  output logic                misal,
  output logic                go
);
  always_comb begin
    desc  = valid ? op_decode(op) : '0;
    misal = is_misaligned(desc.size, ea_lo);
    go    = (desc.load | desc.store) & ~misal;
  end
endmodule

// File: rtl/lsu_be_store_lane.sv
module lsu_be_store_lane
  import lsu_be_pkg::*;
(
  input  acc_size_e           size,
  input  logic [LOFF_W-1:0]   off,
  input  logic [WORD_W-1:0]   src,
  output logic [LANE_N-1:0]   be,
  output logic [WORD_W-1:0]   wdata
);
  int nb_w;
  assign nb_w = size_bytes(size);

  for (genvar l = 0; l < LANE_N; l++) begin : g_lane
    // big-endian: lane l holds the byte at word offset LANE_N-1-l
    localparam int POS = LANE_N - 1 - l;
    logic [LANE_W-1:0] lane_d;

    assign be[l] = (nb_w != 0) && (POS >= int'(off)) && (POS < int'(off) + nb_w);

    always_comb begin
      case (size)
        SZ_BYTE: lane_d = src[0 +: LANE_W];
        SZ_HALF: lane_d = src[(l % 2) * LANE_W +: LANE_W];
        default: lane_d = src[l * LANE_W +: LANE_W];
      endcase
    end

    assign wdata[l*LANE_W +: LANE_W] = lane_d;
  end
endmodule

// File: rtl/lsu_be_load_lane.sv
module lsu_be_load_lane
  import lsu_be_pkg::*;
(
  input  acc_size_e           size,
  input  logic                sext,
  input  logic [LOFF_W-1:0]   off,
  input  logic [WORD_W-1:0]   word,
  output logic [WORD_W-1:0]   data
);
  assign data = load_align(size, sext, off, word);
endmodule

// File: rtl/be_lane_lsu.sv
module be_lane_lsu
  import lsu_be_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid_i,
  input  logic [OP_W-1:0]    acc_op_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [OFF_W-1:0]   offset_i,
  input  logic [WORD_W-1:0]  st_src_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [LANE_N-1:0]  mem_be_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [WORD_W-1:0]  mem_wdata_o,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               misalign_o,
  output logic               ld_valid_o,
  output logic [WORD_W-1:0]  ld_data_o
);

  // named internal events
  logic [ADDR_W-1:0] ea_w;
  acc_desc_t         acc_w;
  logic              misal_w;
  logic              go_w;
  logic [LANE_N-1:0] be_w;
  logic [WORD_W-1:0] wdata_w;
  logic [WORD_W-1:0] ld_word_w;

  // stage 1 load bookkeeping, stage 2 read in flight
  logic              s1_isld;
  acc_size_e         s1_size;
  logic              s1_sext;
  logic              s2_isld;
  acc_size_e         s2_size;
  logic              s2_sext;
  logic [LOFF_W-1:0] s2_off;

  lsu_be_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
    .base (base_i),
    .disp (offset_i),
    .ea   (ea_w)
  );

  lsu_be_decode u_dec (
    .valid (acc_valid_i),
    .op    (acc_op_i),
    .ea_lo (ea_w[LOFF_W-1:0]),
    .desc  (acc_w),
    .misal (misal_w),
    .go    (go_w)
  );

  lsu_be_store_lane u_st (
    .size  (acc_w.size),
    .off   (ea_w[LOFF_W-1:0]),
    .src   (st_src_i),
    .be    (be_w),
    .wdata (wdata_w)
  );

  lsu_be_load_lane u_ld (
    .size (s2_size),
    .sext (s2_sext),
    .off  (s2_off),
    .word (mem_rdata_i),
    .data (ld_word_w)
  );

  // request stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_be_o    <= '0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      misalign_o  <= 1'b0;
      s1_isld     <= 1'b0;
      s1_size     <= SZ_NONE;
      s1_sext     <= 1'b0;
    end else begin
      mem_req_o   <= go_w;
      mem_we_o    <= go_w & acc_w.store;
      mem_be_o    <= go_w ? be_w : '0;
      mem_addr_o  <= ea_w;
      mem_wdata_o <= wdata_w;
      misalign_o  <= misal_w;
      s1_isld     <= go_w & acc_w.load;
      s1_size     <= acc_w.size;
      s1_sext     <= acc_w.sext;
    end
  end

  // read-return stage: remember what the word in flight is for
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_isld <= 1'b0;
      s2_size <= SZ_NONE;
      s2_sext <= 1'b0;
      s2_off  <= '0;
    end else begin
      s2_isld <= s1_isld;
      s2_size <= s1_size;
      s2_sext <= s1_sext;
      s2_off  <= mem_addr_o[LOFF_W-1:0];
    end
  end

  // result stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid_o <= 1'b0;
      ld_data_o  <= '0;
    end else begin
      ld_valid_o <= s2_isld;
      if (s2_isld) ld_data_o <= ld_word_w;
    end
  end

endmodule

// File: rtl/be_lane_lsu_chk.sv
module be_lane_lsu_chk
  import lsu_be_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [LANE_N-1:0] mem_be_o,
  input logic [WORD_W-1:0] mem_wdata_o,
  input logic              misalign_o,
  input logic              ld_valid_o
);

  // R8
  mis_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_o |-> (!mem_req_o && !mem_we_o && mem_be_o == '0));

  // R8
  req_or_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_o, misalign_o}));

  // R5
  we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_req_o);

  // R3
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                   $countones(mem_be_o) == LANE_N));

  // R4
  byte_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $countones(mem_be_o) == 1) |->
      (mem_wdata_o == {LANE_N{mem_wdata_o[LANE_W-1:0]}}));

  // R6
  ld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> ##1 ld_valid_o);

  // R6
  ld_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_o |-> $past(mem_req_o && !mem_we_o, 2));

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> (!mem_req_o && !misalign_o));

endmodule

bind be_lane_lsu be_lane_lsu_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid_i (acc_valid_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_be_o    (mem_be_o),
  .mem_wdata_o (mem_wdata_o),
  .misalign_o  (misalign_o),
  .ld_valid_o  (ld_valid_o)
);

// File: tb/be_lane_lsu_bench.sv
`timescale 1ns/1ps
module be_lane_lsu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_valid = 1'b0;
  logic [5:0]  a_op = '0;
  logic [31:0] a_base = '0;
  logic [15:0] a_off = '0;
  logic [31:0] a_src = '0;

  logic        mem_req_o, mem_we_o, misalign_o, ld_valid_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_addr_o, mem_wdata_o, ld_data_o;
  logic [31:0] mem_rdata_i = '0;

  int compared = 0;
  int mismatched = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  be_lane_lsu u_be_lane_lsu (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(a_valid), .acc_op_i(a_op),
    .base_i(a_base), .offset_i(a_off), .st_src_i(a_src),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_be_o(mem_be_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .misalign_o(misalign_o), .ld_valid_o(ld_valid_o), .ld_data_o(ld_data_o)
  );

  // ---------------- reference arithmetic, written independently ----------------
  function automatic int ref_bytes(input logic [5:0] op);
    if (op == 6'd32 || op == 6'd36 || op == 6'd40) return 1;
    if (op == 6'd33 || op == 6'd37 || op == 6'd41) return 2;
    if (op == 6'd35 || op == 6'd43) return 4;
    return 0;
  endfunction

  function automatic bit ref_is_store(input logic [5:0] op);
    return op == 6'd40 || op == 6'd41 || op == 6'd43;
  endfunction

  function automatic logic [3:0] ref_be(input int nb, input logic [1:0] k);
    if (nb == 1) return 4'b1000 >> k;
    if (nb == 2) return (k >= 2) ? 4'b0011 : 4'b1100;
    if (nb == 4) return 4'b1111;
    return 4'b0000;
  endfunction

  function automatic logic [31:0] ref_wdata(input int nb, input logic [31:0] s);
    if (nb == 1) return {s[7:0], s[7:0], s[7:0], s[7:0]};
    if (nb == 2) return {s[15:0], s[15:0]};
    return s;
  endfunction

  function automatic logic [31:0] ref_extract(input logic [5:0] op, input logic [1:0] k,
                                              input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[31 - 8*k -: 8];
    h = k[1] ? w[15:0] : w[31:16];
    case (op)
      6'd32:   return {{24{b[7]}}, b};
      6'd36:   return {24'h0, b};
      6'd33:   return {{16{h[15]}}, h};
      6'd37:   return {16'h0, h};
      default: return w;
    endcase
  endfunction

  // ---------------- cycle model ----------------
  logic        e_req, e_we, e_mis;
  logic [3:0]  e_be;
  logic [31:0] e_addr, e_wdata;
  logic [5:0]  e_op;
  logic        p_pend;
  logic [5:0]  p_op;
  logic [1:0]  p_k;
  logic        x_valid;
  logic [5:0]  x_op;
  logic [31:0] x_data;

  always @(posedge clk) begin : mdl
    int nb;
    logic [31:0] ea;
    bit mis;
    bit go;
    if (!rst_n) begin
      e_req <= 0; e_we <= 0; e_mis <= 0; e_be <= 0; e_addr <= 0; e_wdata <= 0; e_op <= 0;
      p_pend <= 0; p_op <= 0; p_k <= 0; x_valid <= 0; x_op <= 0; x_data <= 0;
    end else begin
      nb  = a_valid ? ref_bytes(a_op) : 0;
      ea  = a_base + {{16{a_off[15]}}, a_off};
      mis = (nb == 2 && ea[0]) || (nb == 4 && ea[1:0] != 2'b00);
      go  = (nb != 0) && !mis;
      e_req   <= go;
      e_we    <= go && ref_is_store(a_op);
      e_be    <= go ? ref_be(nb, ea[1:0]) : 4'b0000;
      e_addr  <= ea;
      e_wdata <= ref_wdata(nb, a_src);
      e_mis   <= mis;
      e_op    <= a_op;
      p_pend  <= e_req && !e_we;
      p_op    <= e_op;
      p_k     <= e_addr[1:0];
      x_valid <= p_pend;
      x_op    <= p_op;
      if (p_pend) x_data <= ref_extract(p_op, p_k, mem_rdata_i);
    end
  end

  // ---------------- data memory model: 16 words ----------------
  logic [31:0] bmem [16];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) bmem[i] <= 32'hF17F8A05 ^ (32'(i) * 32'h13579BDF);
      mem_rdata_i <= '0;
    end else begin
      if (mem_req_o && mem_we_o)
        for (int l = 0; l < 4; l++)
          if (mem_be_o[l]) bmem[mem_addr_o[5:2]][8*l +: 8] <= mem_wdata_o[8*l +: 8];
      if (mem_req_o && !mem_we_o) mem_rdata_i <= bmem[mem_addr_o[5:2]];
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run) begin
      chk("R2", 32'(mem_req_o), 32'(e_req));
      chk("R5", 32'(mem_we_o), 32'(e_we));
      chk("R3", 32'(mem_be_o), 32'(e_be));
      chk("R8", 32'(misalign_o), 32'(e_mis));
      if (e_req) chk("R1", mem_addr_o, e_addr);
      if (e_we)  chk("R4", mem_wdata_o, e_wdata);
      chk("R6", 32'(ld_valid_o), 32'(x_valid));
      if (x_valid) begin
        if (x_op == 6'd35) chk("R6", ld_data_o, x_data);
        else               chk("R7", ld_data_o, x_data);
      end
    end
  end

  task automatic issue(input bit v, input logic [5:0] op, input logic [31:0] b,
                       input logic [15:0] o, input logic [31:0] s);
    @(negedge clk);
    a_valid = v; a_op = op; a_base = b; a_off = o; a_src = s;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: outputs zero under reset
    chk("R9", {28'h0, mem_req_o, mem_we_o, misalign_o, ld_valid_o}, 32'h0);
    chk("R9", {28'h0, mem_be_o}, 32'h0);
    chk("R9", ld_data_o, 32'h0);
    chk("R9", mem_wdata_o | mem_addr_o, 32'h0);
    rst_n = 1'b1;
    run = 1'b1;

    // plain loads of the initial contents, every offset and size (R6, R7)
    for (int k = 0; k < 4; k++) issue(1, 6'd32, 32'h40, 16'(k), 0);
    for (int k = 0; k < 4; k++) issue(1, 6'd36, 32'h44, 16'(k), 0);
    for (int k = 0; k < 4; k += 2) begin
      issue(1, 6'd33, 32'h48, 16'(k), 0);
      issue(1, 6'd37, 32'h48, 16'(k), 0);
    end
    issue(1, 6'd35, 32'h4C, 16'h0, 0);
    // negative displacement (R1)
    issue(1, 6'd35, 32'h250, 16'hFFF4, 0);
    // word store then byte stores into every lane, then read back (R3, R4)
    issue(1, 6'd43, 32'h100, 16'h0, 32'h11223344);
    for (int k = 0; k < 4; k++) issue(1, 6'd40, 32'h104, 16'(k), 32'hAABBCC80 + 32'(k));
    issue(1, 6'd35, 32'h104, 16'h0, 0);
    issue(1, 6'd41, 32'h108, 16'h0, 32'h5555F00D);
    issue(1, 6'd41, 32'h108, 16'h2, 32'h66668001);
    issue(1, 6'd33, 32'h108, 16'h2, 0);
    issue(1, 6'd37, 32'h108, 16'h2, 0);
    issue(1, 6'd32, 32'h104, 16'h3, 0);
    // misaligned accesses (R8)
    issue(1, 6'd41, 32'h100, 16'h1, 32'hDEADBEEF);
    issue(1, 6'd43, 32'h100, 16'h2, 32'hDEADBEEF);
    issue(1, 6'd35, 32'h100, 16'h3, 0);
    issue(1, 6'd37, 32'h103, 16'h0, 0);
    issue(1, 6'd35, 32'h100, 16'h0, 0);  // word 0 must be untouched by the above
    // undefined opcodes and idle offers (R2)
    issue(1, 6'd34, 32'h100, 16'h0, 32'hFFFFFFFF);
    issue(1, 6'd0, 32'h100, 16'h1, 32'hFFFFFFFF);
    issue(0, 6'd43, 32'h100, 16'h0, 32'hFFFFFFFF);
    issue(1, 6'd35, 32'h100, 16'h0, 0);

    // R10: back-to-back random traffic folding onto sixteen words
    for (int n = 0; n < 4000; n++) begin
      logic [5:0]  op;
      logic [31:0] r;
      r = $urandom;
      case ($urandom % 10)
        0: op = 6'd32; 1: op = 6'd33; 2: op = 6'd35; 3: op = 6'd36; 4: op = 6'd37;
        5: op = 6'd40; 6: op = 6'd41; 7: op = 6'd43; 8: op = 6'd34; default: op = 6'd42;
      endcase
      issue(($urandom % 8) != 0, op, {24'h0, r[15:8]}, {{10{r[5]}}, r[5:0]}, $urandom);
    end
    issue(0, 6'd0, 0, 0, 0);
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R10: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule